// File: doc/BRIEF.md
# Debug Port Capture FIFO

This block sits beside a host I/O decoder and records every host write that lands in a small window of consecutive I/O addresses starting at a fixed base, such as the POST-code debug port. Each recorded write becomes one FIFO entry that holds the written byte and its byte offset within the window. Software on the embedded core reads the entries back through a small register file and rebuilds multi-byte POST codes. An entry with offset 0 starts a new code, and the bytes that follow carry rising offsets.

The core sees four byte-wide registers, selected by a two-bit index:

| Index | Register | Contents |
|-------|----------|----------|
| 0 | Control | Enable flags |
| 1 | Status | Not-empty flag and two sticky event flags |
| 2 | Data | FIFO head entry, optionally popping on each read |
| 3 | Window | Width of the captured address window |

A single interrupt line tells the core that the host has written to the window.

Top module: `dbg_port_capture`

## Requirements
- R1: After reset, the control, status and window registers read 0, the data register reads 0 and `irq_o` is low.
- R2: With capture on, a host write is stored if and only if BASE_ADDR <= address <= BASE_ADDR + window, where the window value is bits 3:0 of register 3. A window value of 0 selects the single base address. A stored entry reads from register 2 with the byte in bits 7:0, the offset (address - BASE_ADDR) in bits 11:8, and zeros above.
- R3: While control bit 0 (capture enable) is 0, host writes store nothing and set no status flag.
- R4: Entries leave in arrival order, and up to DEPTH entries are held. Status bit 0 reads 1 exactly when at least one entry is held.
- R5: A host write that arrives while the FIFO is full is dropped, leaves the held entries unchanged and sets status bit 1 (overflow).
- R6: Status bits 1 and 2 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: Status bit 2 (host-wrote) is set by every write that falls in the window while capture is on, including a write that is dropped.
- R8: With control bit 1 (auto-advance) set, each core read of register 2 removes the head entry. With it clear, reads leave the FIFO untouched, and a core write to register 2 removes the head entry.
- R9: A removal request on an empty FIFO changes nothing. Register 2 then keeps returning the value of the last entry removed.
- R10: `irq_o` equals status bit 2 ANDed with control bit 2 (interrupt enable).
- R11: When the FIFO is full, a host write and a removal in the same cycle both take effect, and overflow is not set.
- R12: Control bits 3:0 read back as written and bits above 3 read 0. Bit 3 (sync mode) does not change capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr_vld | input | 1 | Host I/O write strobe, one cycle per write |
| hst_addr | input | HADDR_W | Host I/O write address |
| hst_wdata | input | DATA_W | Host I/O write byte |
| cpu_rd | input | 1 | Core register read strobe |
| cpu_wr | input | 1 | Core register write strobe |
| cpu_addr | input | 2 | Core register index |
| cpu_wdata | input | WD_W | Core write data |
| cpu_rdata | output | RD_W | Core read data for the selected register |
| irq_o | output | 1 | Core interrupt, level |

## Verification
The bench builds the block with an 8-bit host address, base 80h, a four-entry FIFO and the full 4-bit offset tag. This makes it practical to sweep every window value against every one of the 256 host addresses and check the in-window test and the stored offset at each point. The four-entry depth brings full, overflow and the same-cycle push and pop at full within a few writes. This lets the drop path, the sticky clears and the empty-read hold be checked from exact expected contents.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_STAT  = 2'd1,
      REG_DATA  = 2'd2,
      REG_RANGE = 2'd3
   } reg_sel_e;

   localparam int CTL_W  = 4;
   localparam int ST_NE  = 0;
   localparam int ST_OVF = 1;
   localparam int ST_HW  = 2;

   typedef struct packed {
      logic sync_md;
      logic irq_en;
      logic auto_adv;
      logic en;
   } ctrl_t;

endpackage

// File: rtl/dpc_decode.sv
module dpc_decode #(
   parameter int          HADDR_W    = 16,
   parameter int          OFS_W      = 4,
   parameter int unsigned BASE_ADDR  = 32'h80,
   parameter bit          MULTI_BYTE = 1'b1
) (
   input  logic [HADDR_W-1:0] addr,
   input  logic [OFS_W-1:0]   win,
   output logic               hit,
   output logic [OFS_W-1:0]   ofs
);
   localparam logic [HADDR_W-1:0] BASE_V = BASE_ADDR[HADDR_W-1:0];

   logic [HADDR_W-1:0] diff;
   assign diff = addr - BASE_V;

   generate
      if (MULTI_BYTE) begin : g_window
         logic [HADDR_W-1:0] win_ext;
         assign win_ext = {{(HADDR_W-OFS_W){1'b0}}, win};
         assign hit     = (addr >= BASE_V) && (diff <= win_ext);
         assign ofs     = diff[OFS_W-1:0];
      end else begin : g_single
         logic unused_win;
         assign unused_win = ^win;
         assign hit        = (addr == BASE_V);
         assign ofs        = '0;
      end
   endgenerate
endmodule

// File: rtl/dpc_fifo.sv
module dpc_fifo #(
   parameter int DEPTH     = 16,
   parameter int W         = 12,
   parameter bit RESET_MEM = 1'b1,
   localparam int PTR_W    = $clog2(DEPTH),
   localparam int CNT_W    = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [W-1:0]     mem [DEPTH];
   logic             pop_ok, push_ok;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign pop_ok  = pop_req && !empty;
   assign push_ok = push_req && (!full || pop_ok);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   generate
      if (RESET_MEM) begin : g_mem_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (push_ok) begin
               mem[wr_ptr] <= din;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (push_ok) mem[wr_ptr] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/dpc_regs.sv
module dpc_regs
   import dpc_pkg::*;
#(
   parameter int OFS_W = 4,
   parameter int ENT_W = 12,
   parameter int RD_W  = 16,
   parameter int WD_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_rd,
   input  logic             cpu_wr,
   input  logic [1:0]       cpu_addr,
   input  logic [WD_W-1:0]  cpu_wdata,
   input  logic             in_win_wr,
   input  logic             full,
   input  logic             empty,
   input  logic [ENT_W-1:0] head,
   output ctrl_t            ctrl,
   output logic [OFS_W-1:0] win,
   output logic             pop_req,
   output logic             ovf_q,
   output logic             hw_q,
   output logic [RD_W-1:0]  cpu_rdata,
   output logic             irq
);
   logic [ENT_W-1:0] last_q;
   logic             sel_ctrl, sel_stat, sel_data, sel_win;
   logic             push_req, ovf_set;
   logic             unused_wbits;

   assign sel_ctrl = (cpu_addr == REG_CTRL);
   assign sel_stat = (cpu_addr == REG_STAT);
   assign sel_data = (cpu_addr == REG_DATA);
   assign sel_win  = (cpu_addr == REG_RANGE);

   assign pop_req  = sel_data && (ctrl.auto_adv ? cpu_rd : cpu_wr);
   assign push_req = in_win_wr && ctrl.en;
   assign ovf_set  = push_req && full && !pop_req;
   assign unused_wbits = ^cpu_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         win    <= '0;
         ovf_q  <= 1'b0;
         hw_q   <= 1'b0;
         last_q <= '0;
      end else begin
         if (cpu_wr && sel_ctrl) ctrl <= ctrl_t'(cpu_wdata[CTL_W-1:0]);
         if (cpu_wr && sel_win)  win  <= cpu_wdata[OFS_W-1:0];
         if (ovf_set)
            ovf_q <= 1'b1;
         else if (cpu_wr && sel_stat && cpu_wdata[ST_OVF])
            ovf_q <= 1'b0;
         if (push_req)
            hw_q <= 1'b1;
         else if (cpu_wr && sel_stat && cpu_wdata[ST_HW])
            hw_q <= 1'b0;
         if (pop_req && !empty) last_q <= head;
      end
   end

   always_comb begin
      cpu_rdata = '0;
      unique case (cpu_addr)
         REG_CTRL:  cpu_rdata[CTL_W-1:0] = ctrl;
         REG_STAT: begin
            cpu_rdata[ST_NE]  = !empty;
            cpu_rdata[ST_OVF] = ovf_q;
            cpu_rdata[ST_HW]  = hw_q;
         end
         REG_DATA:  cpu_rdata[ENT_W-1:0] = empty ? last_q : head;
         REG_RANGE: cpu_rdata[OFS_W-1:0] = win;
         default:   cpu_rdata = '0;
      endcase
   end

   assign irq = hw_q && ctrl.irq_en;
endmodule

// File: rtl/dbg_port_capture.sv
module dbg_port_capture
   import dpc_pkg::*;
#(
   parameter int          HADDR_W    = 16,
   parameter int unsigned BASE_ADDR  = 32'h0080,
   parameter int          DATA_W     = 8,
   parameter int          OFS_W      = 4,
   parameter int          DEPTH      = 16,
   parameter int          RD_W       = 16,
   parameter int          WD_W       = 8,
   parameter bit          MULTI_BYTE = 1'b1,
   parameter bit          RESET_MEM  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hst_wr_vld,
   input  logic [HADDR_W-1:0] hst_addr,
   input  logic [DATA_W-1:0]  hst_wdata,
   input  logic               cpu_rd,
   input  logic               cpu_wr,
   input  logic [1:0]         cpu_addr,
   input  logic [WD_W-1:0]    cpu_wdata,
   output logic [RD_W-1:0]    cpu_rdata,
   output logic               irq_o
);
   localparam int ENT_W = DATA_W + OFS_W;
   localparam int CNT_W = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (ENT_W > RD_W) begin : g_bad_rd
         $error("entry does not fit in read data width");
      end
      if (OFS_W >= HADDR_W || OFS_W > WD_W || CTL_W > WD_W) begin : g_bad_ofs
         $error("offset or control field too wide");
      end
      if (BASE_ADDR + (1 << OFS_W) > (64'd1 << HADDR_W)) begin : g_bad_base
         $error("capture window exceeds host address space");
      end
   endgenerate

   ctrl_t              ctl;
   logic [OFS_W-1:0]   win, ofs;
   logic               hit, in_win_wr, push_req, pop_req;
   logic               full, empty, ovf_q, hw_q;
   logic               ctl_en, clr_ovf;
   logic [ENT_W-1:0]   head;
   logic [CNT_W-1:0]   count;

   dpc_decode #(
      .HADDR_W(HADDR_W), .OFS_W(OFS_W),
      .BASE_ADDR(BASE_ADDR), .MULTI_BYTE(MULTI_BYTE)
   ) u_decode (
      .addr(hst_addr), .win(win), .hit(hit), .ofs(ofs)
   );

   assign in_win_wr = hst_wr_vld && hit;
   assign ctl_en    = ctl.en;
   assign push_req  = in_win_wr && ctl_en;
   assign clr_ovf   = cpu_wr && (cpu_addr == REG_STAT) && cpu_wdata[ST_OVF];

   dpc_fifo #(
      .DEPTH(DEPTH), .W(ENT_W), .RESET_MEM(RESET_MEM)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_req(push_req), .pop_req(pop_req),
      .din({ofs, hst_wdata}), .dout(head),
      .count(count), .full(full), .empty(empty)
   );

   dpc_regs #(
      .OFS_W(OFS_W), .ENT_W(ENT_W), .RD_W(RD_W), .WD_W(WD_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .in_win_wr(in_win_wr),
      .full(full), .empty(empty), .head(head),
      .ctrl(ctl), .win(win), .pop_req(pop_req),
      .ovf_q(ovf_q), .hw_q(hw_q),
      .cpu_rdata(cpu_rdata), .irq(irq_o)
   );
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hst_wr_vld,
   input logic             ctl_en,
   input logic             push_req,
   input logic             pop_req,
   input logic             full,
   input logic             empty,
   input logic [CNT_W-1:0] count,
   input logic             ovf_q,
   input logic             clr_ovf
);
   assert_no_capture_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr_vld && !ctl_en) |=> (count <= $past(count)));

   assert_count_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count <= CNT_W'(DEPTH)));

   assert_drop_sets_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !pop_req) |=> (ovf_q && count == CNT_W'(DEPTH)));

   assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_ovf) |=> ovf_q);

   assert_empty_pop_harmless_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty && !push_req) |=> empty);

   assert_full_passthrough_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && pop_req && full) |=> (count == CNT_W'(DEPTH) && !(ovf_q && !$past(ovf_q))));
endmodule

bind dbg_port_capture dpc_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dpc_chk (
   .clk(clk), .rst_n(rst_n), .hst_wr_vld(hst_wr_vld), .ctl_en(ctl_en),
   .push_req(push_req), .pop_req(pop_req), .full(full), .empty(empty),
   .count(count), .ovf_q(ovf_q), .clr_ovf(clr_ovf)
);

// File: tb/dbg_port_capture_bench.sv
`timescale 1ns/1ps
module dbg_port_capture_bench;
   localparam int HW = 8;
   localparam int BASE = 'h80;
   localparam int DEP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hst_wr_vld = 1'b0;
   logic [HW-1:0] hst_addr = '0;
   logic [7:0]    hst_wdata = '0;
   logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [1:0]    cpu_addr = '0;
   logic [7:0]    cpu_wdata = '0;
   logic [15:0]   cpu_rdata;
   logic          irq_o;

   int total = 0, bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dbg_port_capture #(
      .HADDR_W(HW), .BASE_ADDR(BASE), .DATA_W(8), .OFS_W(4), .DEPTH(DEP),
      .RD_W(16), .WD_W(8), .MULTI_BYTE(1'b1), .RESET_MEM(1'b1)
   ) u_dbg_port_capture (
      .clk(clk), .rst_n(rst_n), .hst_wr_vld(hst_wr_vld), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [HW-1:0] a, input logic [7:0] d);
      hst_wr_vld = 1'b1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_wr_vld = 1'b0;
   endtask

   task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [1:0] a, output logic [15:0] v);
      cpu_rd = 1'b1; cpu_addr = a;
      #1 v = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   function automatic logic [15:0] ent(input int ofs, input logic [7:0] d);
      return {4'h0, 4'(ofs), d};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cpu_read(0, v); check("R1 ctrl", v, 16'h0);
      cpu_read(1, v); check("R1 status", v, 16'h0);
      cpu_read(3, v); check("R1 window", v, 16'h0);
      cpu_read(2, v); check("R1 data", v, 16'h0);
      check("R1 irq", {15'h0, irq_o}, 16'h0);

      // R3 capture off
      host_wr(8'h80, 8'hA5);
      cpu_read(1, v); check("R3 status after write while off", v, 16'h0);
      check("R3 irq", {15'h0, irq_o}, 16'h0);

      // R12 control readback, sync mode has no effect
      cpu_write(0, 8'hFF);
      cpu_read(0, v); check("R12 ctrl readback", v, 16'h000F);
      cpu_write(0, 8'h3A);
      cpu_read(0, v); check("R12 ctrl readback 2", v, 16'h000A);
      cpu_write(0, 8'h0B);
      host_wr(8'h80, 8'h3C);
      cpu_read(2, v); check("R12 capture in sync mode", v, ent(0, 8'h3C));
      cpu_read(1, v); check("R12 empty after pop", v, 16'h0004);
      cpu_write(1, 8'h06);

      // R2 sweep: every window value against every address
      cpu_write(0, 8'h03);
      for (int r = 0; r < 16; r++) begin
         cpu_write(3, 8'(r));
         for (int a = 0; a < 256; a++) begin
            bit inw;
            d = 8'(a) ^ 8'(r * 17);
            inw = (a >= BASE) && (a <= BASE + r);
            host_wr(8'(a), d);
            cpu_read(1, v);
            check($sformatf("R2 hit r=%0d a=%0h", r, a), {15'h0, v[0]}, {15'h0, inw});
            if (inw) begin
               cpu_read(2, v);
               check($sformatf("R2 entry r=%0d a=%0h", r, a), v, ent(a - BASE, d));
            end
         end
      end
      cpu_read(3, v); check("R2 window readback", v, 16'h000F);
      cpu_read(1, v); check("R7 host-wrote after sweep", v, 16'h0004);

      // R4/R5/R6/R7 fill, overflow, sticky clears
      cpu_write(1, 8'h06);
      for (int i = 0; i < 5; i++) host_wr(8'(BASE + i), 8'(i + 1));
      cpu_read(1, v); check("R5 overflow and R7 host-wrote", v, 16'h0007);
      cpu_write(1, 8'h00);
      cpu_read(1, v); check("R6 write 0 keeps flags", v, 16'h0007);
      cpu_write(1, 8'h02);
      cpu_read(1, v); check("R6 clear overflow only", v, 16'h0005);
      cpu_write(1, 8'h04);
      cpu_read(1, v); check("R6 clear host-wrote", v, 16'h0001);
      for (int i = 0; i < 4; i++) begin
         cpu_read(2, v); check("R4 order, R5 drop kept contents", v, ent(i, 8'(i + 1)));
      end
      cpu_read(1, v); check("R4 empty after drain", v, 16'h0000);

      // R9 empty read holds last value
      cpu_read(2, v); check("R9 empty read returns last", v, ent(3, 8'h04));
      cpu_read(2, v); check("R9 empty read repeat", v, ent(3, 8'h04));
      cpu_read(1, v); check("R9 still empty", v, 16'h0000);
      host_wr(8'h82, 8'h99);
      cpu_read(2, v); check("R9 new entry after empty reads", v, ent(2, 8'h99));
      cpu_write(1, 8'h06);

      // R8 manual advance
      cpu_write(0, 8'h01);
      host_wr(8'h80, 8'hAA);
      host_wr(8'h81, 8'hBB);
      cpu_read(2, v); check("R8 read without pop", v, ent(0, 8'hAA));
      cpu_read(2, v); check("R8 read again same", v, ent(0, 8'hAA));
      cpu_write(2, 8'h00);
      cpu_read(2, v); check("R8 write pops", v, ent(1, 8'hBB));
      cpu_write(2, 8'h00);
      cpu_read(1, v); check("R8 empty after write pops", v, 16'h0004);
      cpu_write(1, 8'h06);

      // R10 interrupt
      cpu_write(0, 8'h05);
      check("R10 irq idle", {15'h0, irq_o}, 16'h0);
      host_wr(8'h80, 8'h10);
      check("R10 irq after write", {15'h0, irq_o}, 16'h1);
      cpu_write(0, 8'h01);
      check("R10 irq masked", {15'h0, irq_o}, 16'h0);
      cpu_write(0, 8'h05);
      check("R10 irq unmasked", {15'h0, irq_o}, 16'h1);
      cpu_write(1, 8'h04);
      check("R10 irq after clear", {15'h0, irq_o}, 16'h0);
      cpu_write(2, 8'h00);

      // R11 push and pop together when full
      cpu_write(0, 8'h03);
      cpu_write(1, 8'h06);
      for (int i = 0; i < 4; i++) host_wr(8'h80, 8'(8'h11 * (i + 1)));
      hst_wr_vld = 1'b1; hst_addr = 8'h80; hst_wdata = 8'h55;
      cpu_rd = 1'b1; cpu_addr = 2'd2;
      #1 v = cpu_rdata;
      check("R11 head during simultaneous op", v, ent(0, 8'h11));
      @(negedge clk);
      hst_wr_vld = 1'b0; cpu_rd = 1'b0;
      cpu_read(1, v); check("R11 no overflow", v, 16'h0005);
      for (int i = 1; i < 5; i++) begin
         cpu_read(2, v); check("R11 contents", v, ent(0, 8'(8'h11 * (i + 1))));
      end
      cpu_read(1, v); check("R11 drained", v, 16'h0004);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule